// File: doc/BRIEF.md
# Battery Monitor Sleep-State Controller

This block decides when a battery-monitor chip leaves its full-power NORMAL state for a low-power SLEEP state, and when it must come back. In NORMAL it watches the per-interval filtered current reading. When SLEEP is permitted, no re-entry hold is running and the reading's magnitude is small, it drops into SLEEP. In SLEEP it watches a set of wake causes. Two of them are current checks: a fast current sample, examined on every 12th millisecond tick, and the per-interval reading. The others are a charger-insertion test on the pack and stack voltages, a protection fault, a charger-detect flag, host commands, and a short pulse on the reset/shutdown pin.

Every return to NORMAL loads a re-entry hold, counted in seconds. A wake caused by current gives a one-cycle FET re-enable pulse together with the fall of the sleep flag. Measurement restart is deferred to the next one-second boundary of a free-running timebase, which is built from an external 1 ms tick.

Top module: `battery_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low, `sleep_state`, `fet_reenable` and `meas_restart` are 0, `sleep_allowed` takes the value of `cfg_sleep_en`, and the tick counters and the hold counter are cleared.
- R2: `cmd_disallow` clears `sleep_allowed` at the next edge. Otherwise `cmd_allow` sets it. When both arrive in the same cycle, `cmd_disallow` wins.
- R3: In NORMAL, a cycle with `intv_cur_vld` high moves the block to SLEEP at the next edge when all of these hold: the magnitude of `intv_cur` is strictly below `thr_cur`, `sleep_allowed` is 1, `cmd_disallow` is low, the hold counter is zero, and `fault` and `chg_det` are low. A magnitude equal to `thr_cur` does not enter.
- R4: The fast check strobe occurs on every 12th `ms_tick` counted from reset. In SLEEP, a strobe cycle in which the magnitude of `fast_cur` is strictly above `thr_cur` returns the block to NORMAL at the next edge. `fast_cur` has no effect in any other cycle.
- R5: In SLEEP, an `intv_cur_vld` cycle in which the magnitude of `intv_cur` is strictly above `thr_cur` returns the block to NORMAL.
- R6: Current inputs are 16-bit two's complement. Magnitude is the absolute value, and the code 0x8000 saturates to 0x7FFF.
- R7: In SLEEP, a `volt_vld` cycle returns the block to NORMAL when `pack_mv` > `stack_mv` + `thr_delta` (compared without overflow) and `stack_mv` < `thr_stack`.
- R8: In SLEEP, any of `fault`, `chg_det`, `cmd_force_exit` or `cmd_disallow` returns the block to NORMAL at the next edge.
- R9: `pin_rst` is active high. Its hold time is the number of `ms_tick` cycles it stays high, counting the rising cycle. A release after fewer than 1000 ticks wakes the block from SLEEP in the release cycle. A release after 1000 or more ticks has no effect.
- R10: Each return to NORMAL loads `hyst_sec` into the hold counter. The counter decrements, if nonzero, on every 1000th `ms_tick` counted from reset. SLEEP entry is blocked while it is nonzero.
- R11: `fet_reenable` is a one-cycle pulse that coincides with `sleep_state` falling. It occurs only when the wake cycle held a fast or interval current trip.
- R12: A return to NORMAL arms a pending restart. `meas_restart` pulses for one cycle just after the first one-second boundary tick that falls strictly after the wake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sleep_en | input | 1 | SLEEP permission value loaded during reset |
| cmd_allow | input | 1 | Host pulse: permit SLEEP |
| cmd_disallow | input | 1 | Host pulse: forbid SLEEP (also forces wake) |
| cmd_force_exit | input | 1 | Host pulse: force wake |
| ms_tick | input | 1 | One-cycle 1 ms timebase tick |
| fast_cur | input | 16 | Signed fast current sample |
| intv_cur_vld | input | 1 | Interval current reading valid |
| intv_cur | input | 16 | Signed filtered interval current |
| volt_vld | input | 1 | Voltage samples valid |
| pack_mv | input | 16 | Pack terminal voltage |
| stack_mv | input | 16 | Top-of-stack voltage |
| fault | input | 1 | Protection fault flag |
| chg_det | input | 1 | Charger detect flag |
| pin_rst | input | 1 | Reset/shutdown pin, active high |
| thr_cur | input | 16 | Sleep current threshold (unsigned) |
| thr_delta | input | 16 | Pack-over-stack delta |
| thr_stack | input | 16 | Stack voltage ceiling for charger wake |
| hyst_sec | input | 8 | Re-entry hold in seconds |
| sleep_state | output | 1 | 1 while in SLEEP |
| sleep_allowed | output | 1 | Current SLEEP permission |
| fet_reenable | output | 1 | FET restore pulse on current wake |
| meas_restart | output | 1 | Measurement-loop restart strobe |

## Verification
The cycle that matters most is a wake that lands on a one-second boundary tick. In that cycle the hold counter is loaded and would also be decremented, and the restart must be pushed past this boundary to the next one. The bench provokes this by letting random wake causes meet a randomly gated `ms_tick`. A cycle-accurate model in the bench, built from the requirements, judges the load-over-decrement priority and the deferred strobe. A second collision is a quiet interval reading that arrives with `cmd_disallow` in the same cycle. The model checks that permission falls and that no entry takes place.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {ST_NORMAL = 1'b0, ST_SLEEP = 1'b1} slp_state_e;
endpackage

// File: rtl/slp_timebase.sv
module slp_timebase #(
  parameter int CHK_MS = 12,
  parameter int SEC_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  output logic chk_stb,
  output logic sec_stb
);
  localparam int CKW = $clog2(CHK_MS);
  localparam int SCW = $clog2(SEC_MS);

  logic [CKW-1:0] chk_cnt;
  logic [SCW-1:0] sec_cnt;

  assign chk_stb = ms_tick && (chk_cnt == CKW'(CHK_MS - 1));
  assign sec_stb = ms_tick && (sec_cnt == SCW'(SEC_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_cnt <= '0;
      sec_cnt <= '0;
    end else if (ms_tick) begin
      chk_cnt <= chk_stb ? '0 : chk_cnt + 1'b1;
      sec_cnt <= sec_stb ? '0 : sec_cnt + 1'b1;
    end
  end

  // R4: strobes stay apart by at least one cycle
  p_chk_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb |=> !chk_stb);
endmodule

// File: rtl/slp_pin_gauge.sv
module slp_pin_gauge #(
  parameter int SEC_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pin,
  output logic short_release
);
  localparam int GW = $clog2(SEC_MS + 1);

  logic          pin_q;
  logic [GW-1:0] held;

  assign short_release = pin_q && !pin && (held < GW'(SEC_MS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      held  <= '0;
    end else begin
      pin_q <= pin;
      if (pin && !pin_q)
        held <= GW'(ms_tick);
      else if (pin && ms_tick && held != GW'(SEC_MS))
        held <= held + 1'b1;
    end
  end

  p_release_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_release |-> ($past(pin) && !pin));
endmodule

// File: rtl/slp_hold_timer.sv
module slp_hold_timer #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] load_val,
  input  logic          sec_stb,
  output logic [HW-1:0] cnt,
  output logic          zero
);
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (sec_stb && !zero)
      cnt <= cnt - 1'b1;
  end

  p_hold_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> cnt == $past(load_val));
endmodule

// File: rtl/battery_sleep_ctrl.sv
module battery_sleep_ctrl #(
  parameter int CW     = 16,
  parameter int VW     = 16,
  parameter int HW     = 8,
  parameter int CHK_MS = 12,
  parameter int SEC_MS = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_sleep_en,
  input  logic                 cmd_allow,
  input  logic                 cmd_disallow,
  input  logic                 cmd_force_exit,
  input  logic                 ms_tick,
  input  logic signed [CW-1:0] fast_cur,
  input  logic                 intv_cur_vld,
  input  logic signed [CW-1:0] intv_cur,
  input  logic                 volt_vld,
  input  logic [VW-1:0]        pack_mv,
  input  logic [VW-1:0]        stack_mv,
  input  logic                 fault,
  input  logic                 chg_det,
  input  logic                 pin_rst,
  input  logic [CW-1:0]        thr_cur,
  input  logic [VW-1:0]        thr_delta,
  input  logic [VW-1:0]        thr_stack,
  input  logic [HW-1:0]        hyst_sec,
  output logic                 sleep_state,
  output logic                 sleep_allowed,
  output logic                 fet_reenable,
  output logic                 meas_restart
);
  import slp_pkg::*;

  localparam logic [CW-1:0] MAG_MAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] NEG_MIN = {1'b1, {(CW-1){1'b0}}};

  // R6: absolute value with saturation of the most negative code
  function automatic logic [CW-1:0] cur_mag(input logic signed [CW-1:0] v);
    if (!v[CW-1]) return v;
    if (v == NEG_MIN) return MAG_MAX;
    return -v;
  endfunction

  // R7: pack above stack by more than delta, one extra bit against overflow
  function automatic logic pack_high(input logic [VW-1:0] p, s, d);
    return {1'b0, p} > ({1'b0, s} + {1'b0, d});
  endfunction

  slp_state_e    state;
  logic          chk_stb, sec_stb, pin_wake;
  logic          hold_zero;
  logic [HW-1:0] hold_cnt;
  logic          restart_pend;

  slp_timebase #(.CHK_MS(CHK_MS), .SEC_MS(SEC_MS)) u_tb (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .chk_stb(chk_stb), .sec_stb(sec_stb));

  slp_pin_gauge #(.SEC_MS(SEC_MS)) u_pin (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin(pin_rst),
    .short_release(pin_wake));

  // named events
  logic fast_trip, intv_trip, intv_quiet, chg_trip, cur_wake, other_wake;
  logic exit_now, enter_now;

  assign fast_trip  = chk_stb && (cur_mag(fast_cur) > thr_cur);
  assign intv_trip  = intv_cur_vld && (cur_mag(intv_cur) > thr_cur);
  assign intv_quiet = intv_cur_vld && (cur_mag(intv_cur) < thr_cur);
  assign chg_trip   = volt_vld && pack_high(pack_mv, stack_mv, thr_delta)
                      && (stack_mv < thr_stack);
  assign cur_wake   = fast_trip || intv_trip;
  assign other_wake = fault || chg_det || cmd_force_exit || cmd_disallow
                      || chg_trip || pin_wake;
  assign exit_now   = (state == ST_SLEEP) && (cur_wake || other_wake);
  assign enter_now  = (state == ST_NORMAL) && sleep_allowed && !cmd_disallow
                      && hold_zero && intv_quiet && !fault && !chg_det;

  slp_hold_timer #(.HW(HW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(exit_now), .load_val(hyst_sec),
    .sec_stb(sec_stb), .cnt(hold_cnt), .zero(hold_zero));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_NORMAL;
      sleep_allowed <= cfg_sleep_en;
      fet_reenable  <= 1'b0;
      meas_restart  <= 1'b0;
      restart_pend  <= 1'b0;
    end else begin
      if (cmd_disallow)   sleep_allowed <= 1'b0;
      else if (cmd_allow) sleep_allowed <= 1'b1;

      if (exit_now)       state <= ST_NORMAL;
      else if (enter_now) state <= ST_SLEEP;

      fet_reenable <= exit_now && cur_wake;
      meas_restart <= restart_pend && sec_stb;

      if (exit_now)     restart_pend <= 1'b1;
      else if (sec_stb) restart_pend <= 1'b0;
    end
  end

  assign sleep_state = (state == ST_SLEEP);

  p_fet_with_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fet_reenable |-> (!sleep_state && $past(sleep_state)));
  p_restart_on_boundary_r12: assert property (@(posedge clk) disable iff (!rst_n)
    meas_restart |-> $past(sec_stb));
  p_entry_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_state) |-> $past(hold_zero && sleep_allowed));
  p_fault_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state && fault) |=> !sleep_state);
  p_disallow_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_disallow |=> !sleep_allowed);
endmodule

// File: tb/battery_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module battery_sleep_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, cfg_sleep_en, cmd_allow, cmd_disallow, cmd_force_exit, ms_tick;
  logic signed [15:0] fast_cur, intv_cur;
  logic intv_cur_vld, volt_vld, fault, chg_det, pin_rst;
  logic [15:0] pack_mv, stack_mv, thr_cur, thr_delta, thr_stack;
  logic [7:0]  hyst_sec;
  logic sleep_state, sleep_allowed, fet_reenable, meas_restart;

  int checks = 0, failures = 0;
  int tick_mode = 1;  // 0 none, 1 every cycle, 2 random
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  battery_sleep_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int magof(input logic signed [15:0] v);
    int x = int'(v);
    if (x < 0) x = -x;
    return (x > 32767) ? 32767 : x;
  endfunction

  bit m_sleep, m_allow, m_fet, m_rst, m_pend, m_pin_prev;
  int m_ticks, m_hold, m_pin_len;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sleep <= 0; m_allow <= cfg_sleep_en; m_fet <= 0; m_rst <= 0; m_pend <= 0;
      m_ticks <= 0; m_hold <= 0; m_pin_len <= 0; m_pin_prev <= 0;
    end else begin
      bit chk12, sec, cur, other, wake, enter, pinw;
      chk12 = ms_tick && ((m_ticks + 1) % 12 == 0);
      sec   = ms_tick && ((m_ticks + 1) % 1000 == 0);
      pinw  = m_pin_prev && !pin_rst && (m_pin_len < 1000);
      cur   = (chk12 && magof(fast_cur) > int'(thr_cur)) ||
              (intv_cur_vld && magof(intv_cur) > int'(thr_cur));
      other = fault || chg_det || cmd_force_exit || cmd_disallow || pinw ||
              (volt_vld && (int'(pack_mv) - int'(stack_mv) > int'(thr_delta)) &&
               stack_mv < thr_stack);
      wake  = m_sleep && (cur || other);
      enter = !m_sleep && m_allow && !cmd_disallow && m_hold == 0 && intv_cur_vld &&
              magof(intv_cur) < int'(thr_cur) && !fault && !chg_det;
      if (ms_tick) m_ticks <= m_ticks + 1;
      m_sleep <= wake ? 1'b0 : (enter ? 1'b1 : m_sleep);
      m_allow <= cmd_disallow ? 1'b0 : (cmd_allow ? 1'b1 : m_allow);
      m_fet   <= wake && cur;
      m_rst   <= m_pend && sec;
      m_pend  <= wake ? 1'b1 : (sec ? 1'b0 : m_pend);
      if (wake) m_hold <= int'(hyst_sec);
      else if (sec && m_hold > 0) m_hold <= m_hold - 1;
      m_pin_prev <= pin_rst;
      if (pin_rst && !m_pin_prev) m_pin_len <= ms_tick ? 1 : 0;
      else if (pin_rst && ms_tick && m_pin_len < 1000) m_pin_len <= m_pin_len + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R5 R7 R8 model sleep_state", sleep_state, m_sleep);
      chk("R2 model sleep_allowed", sleep_allowed, m_allow);
      chk("R11 model fet_reenable", fet_reenable, m_fet);
      chk("R12 model meas_restart", meas_restart, m_rst);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      case (tick_mode)
        0: ms_tick = 0;
        1: ms_tick = 1;
        default: ms_tick = ($urandom % 4) != 0;
      endcase
    end
  endtask

  task automatic pulse_intv(input logic signed [15:0] v);
    intv_cur_vld = 1; intv_cur = v; step(); intv_cur_vld = 0; intv_cur = 0;
  endtask

  task automatic go_sleep();
    for (int i = 0; i < 4000 && !sleep_state; i++) pulse_intv(16'sd0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h51EE9));
    rst_n = 0; cfg_sleep_en = 1; cmd_allow = 0; cmd_disallow = 0; cmd_force_exit = 0;
    ms_tick = 0; fast_cur = 0; intv_cur_vld = 0; intv_cur = 0; volt_vld = 0;
    pack_mv = 0; stack_mv = 0; fault = 0; chg_det = 0; pin_rst = 0;
    thr_cur = 100; thr_delta = 1000; thr_stack = 4500; hyst_sec = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset sleep_state", sleep_state, 0);
    chk("R1 reset allowed=cfg", sleep_allowed, 1);
    chk("R1 reset fet", fet_reenable, 0);
    chk("R1 reset restart", meas_restart, 0);
    rst_n = 1; ms_tick = 1;

    // R3: equal magnitude does not enter; smaller does
    pulse_intv(16'sd100);
    chk("R3 equal magnitude stays NORMAL", sleep_state, 0);
    pulse_intv(-16'sd99);
    chk("R3 quiet reading enters SLEEP", sleep_state, 1);

    // R4: fast sample ignored without strobe, trips on strobe
    tick_mode = 0; ms_tick = 0; fast_cur = 16'sd500;
    step(30);
    chk("R4 fast sample ignored off strobe", sleep_state, 1);
    tick_mode = 1; ms_tick = 1;
    for (int i = 0; i < 14 && sleep_state; i++) step();
    chk("R4 fast trip wakes", sleep_state, 0);
    chk("R11 fet pulse on current wake", fet_reenable, 1);
    fast_cur = 0;
    step();
    chk("R11 fet pulse lasts one cycle", fet_reenable, 0);

    // R12: restart arrives at a boundary
    begin
      bit seen = 0;
      for (int i = 0; i < 1100 && !seen; i++) begin step(); seen = meas_restart; end
      chk("R12 restart strobe seen", seen, 1);
    end

    // R2: disallow wins over allow
    cmd_allow = 1; cmd_disallow = 1; step(); cmd_allow = 0; cmd_disallow = 0;
    chk("R2 disallow wins", sleep_allowed, 0);
    pulse_intv(16'sd0);
    chk("R2 no entry while forbidden", sleep_state, 0);
    cmd_allow = 1; step(); cmd_allow = 0;
    chk("R2 allow sets", sleep_allowed, 1);

    // R6: saturation of most negative code
    go_sleep();
    thr_cur = 16'h7FFF;
    pulse_intv(16'sh8000);
    chk("R6 saturated magnitude equals max, stays", sleep_state, 1);
    thr_cur = 16'h7FFE;
    pulse_intv(16'sh8000);
    chk("R6 R5 saturated magnitude above threshold wakes", sleep_state, 0);
    chk("R11 fet on interval wake", fet_reenable, 1);
    thr_cur = 100;

    // R7: charger test
    go_sleep();
    volt_vld = 1; pack_mv = 5000; stack_mv = 4000; step();
    chk("R7 delta not exceeded stays", sleep_state, 1);
    pack_mv = 6000; stack_mv = 4500; step();
    chk("R7 stack not below threshold stays", sleep_state, 1);
    pack_mv = 5001; stack_mv = 4000; step(); volt_vld = 0;
    chk("R7 charger test wakes", sleep_state, 0);
    chk("R11 no fet on voltage wake", fet_reenable, 0);

    // R8: other causes
    go_sleep(); fault = 1; step(); fault = 0;
    chk("R8 fault wakes", sleep_state, 0);
    go_sleep(); chg_det = 1; step(); chg_det = 0;
    chk("R8 charger flag wakes", sleep_state, 0);
    go_sleep(); cmd_force_exit = 1; step(); cmd_force_exit = 0;
    chk("R8 force exit wakes", sleep_state, 0);
    go_sleep(); cmd_disallow = 1; step(); cmd_disallow = 0;
    chk("R8 disallow wakes", sleep_state, 0);
    cmd_allow = 1; step(); cmd_allow = 0;

    // R9: pin pulse lengths
    go_sleep();
    pin_rst = 1; step(1000); pin_rst = 0; step(2);
    chk("R9 long pin hold ignored", sleep_state, 1);
    pin_rst = 1; step(999); pin_rst = 0; step();
    chk("R9 short pin pulse wakes", sleep_state, 0);

    // R10: hysteresis
    hyst_sec = 2;
    go_sleep(); cmd_force_exit = 1; step(); cmd_force_exit = 0;
    pulse_intv(16'sd0);
    chk("R10 entry blocked during hold", sleep_state, 0);
    begin
      int n = 0;
      for (int i = 0; i < 4000 && !sleep_state; i++) begin pulse_intv(16'sd0); n++; end
      chk("R10 entry after hold expires", sleep_state, 1);
      chk("R10 hold lasted over one second", (n > 1000), 1);
    end

    // random phase: causes collide with boundaries
    tick_mode = 2; hyst_sec = 1; thr_cur = 1000;
    for (int i = 0; i < 6000; i++) begin
      intv_cur_vld = ($urandom % 3) == 0;
      intv_cur = 16'($signed($urandom % 2400) - 1200);
      fast_cur = 16'($signed($urandom % 2400) - 1200);
      volt_vld = ($urandom % 8) == 0;
      pack_mv = 16'(4000 + $urandom % 2000); stack_mv = 16'(3500 + $urandom % 1500);
      fault = ($urandom % 200) == 0; chg_det = ($urandom % 200) == 0;
      cmd_force_exit = ($urandom % 150) == 0;
      cmd_disallow = ($urandom % 300) == 0; cmd_allow = ($urandom % 20) == 0;
      if ($urandom % 100 == 0) pin_rst = ~pin_rst;
      hyst_sec = 8'($urandom % 2);
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule